// File: doc/BRIEF.md
# NCO Complex IQ Up-Modulator

This block takes two interpolated baseband streams, in-phase (I) and quadrature (Q), one sample of each per clock. It shifts the complex signal up to an intermediate frequency. A numerically controlled oscillator supplies the carrier. A 32-bit tuning word sets the carrier frequency at `tune_word × f_clk / 2^32`. A separate 16-bit phase offset rotates the carrier. Both words come as static configuration from a register bank outside the block.

A 3-bit mode code picks the output. The two streams can pass straight through, or the block can produce upper or lower single-sideband up-conversion. Two output channels appear on every clock. Each is rounded and saturated back to the input sample width. The pipeline depth is the same in every mode, so switching between pass-through and mixing never shifts the sample alignment downstream.

Top module: `nco_iq_upmod`

## Requirements
- R1: While `rst_ni` is low, both output channels read zero.
- R2: Every output sample leaves the block exactly 4 clock edges after the edge that captured its input sample. This holds in every mode.
- R3: With the enable high, mode codes 000, 011, 100, 101, 110 and 111 are pass-through: channel A carries I and channel B carries Q. Samples are two's complement.
- R4: While `nco_en_i` is low, the phase accumulator does not advance and every mode acts as pass-through. When the enable returns high, the accumulator resumes from the value it held.
- R5: The accumulator is zero after reset. It adds the tuning word modulo 2^32 at every edge while enabled. The sample captured at an edge uses the accumulator value from before that edge's update. The table address is bits [15:6] of (accumulator[31:16] + phase offset) mod 2^16.
- R6: For table address p in 0..1023, sine(p) = round(8191·sin(2π(p+0.5)/1024)), rounded symmetrically about zero, and cosine(p) = sine((p+256) mod 1024).
- R7: Mode 001 (enable high) gives upper sideband: A = (I·cos − Q·sin)/8192 and B = (I·sin + Q·cos)/8192.
- R8: Mode 010 (enable high) gives lower sideband: A = (I·cos + Q·sin)/8192 and B = (Q·cos − I·sin)/8192.
- R9: Each mixed result is formed as floor((sum + 4096) / 8192) and then clamped to [−2048, 2047].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nco_en_i | input | 1 | Oscillator enable; low freezes phase and forces pass-through |
| mix_mode_i | input | 3 | Output mode: 000 pass, 001 upper sideband, 010 lower sideband, others pass |
| tune_word_i | input | 32 | Frequency tuning word |
| phase_ofs_i | input | 16 | Phase offset added to the upper accumulator half |
| samp_i_i | input | 12 | In-phase sample, two's complement |
| samp_q_i | input | 12 | Quadrature sample, two's complement |
| chan_a_o | output | 12 | Output channel A |
| chan_b_o | output | 12 | Output channel B |

## Verification
Both output channels are due 4 edges after the edge that captured the input sample, the enable, the mode and the phase in use. Every output is registered, so it is stable between edges. The bench computes each expected pair when it presents the input and pushes the pair into a 4-entry queue. It compares the oldest entry at the falling edge after the fourth rising edge. An output that arrives early or late therefore mismatches on every changing sample, including the isolated impulses used for R2. The oscillator model advances its own copy of the accumulator at the same edges. Changes to configuration, enable and mode take effect on the same sample in the bench and in the design.

// File: rtl/nco_upmod_pkg.sv
package nco_upmod_pkg;

  // Mode codes: the encoding is decoded at the block edge.
  localparam logic [2:0] MODE_PASS  = 3'b000;
  localparam logic [2:0] MODE_UPPER = 3'b001;
  localparam logic [2:0] MODE_LOWER = 3'b010;

  // Internal mixing selection carried down the pipeline.
  typedef enum logic [1:0] {
    MIX_PASS  = 2'd0,
    MIX_UPPER = 2'd1,
    MIX_LOWER = 2'd2
  } mix_kind_e;

  // A disabled oscillator and any unlisted code both fall back to pass-through.
  function automatic mix_kind_e decode_mode(input logic en, input logic [2:0] code);
    mix_kind_e k;
    k = MIX_PASS;
    if (en) begin
      if (code == MODE_UPPER)      k = MIX_UPPER;
      else if (code == MODE_LOWER) k = MIX_LOWER;
    end
    return k;
  endfunction

  // Quarter-wave magnitude at a half-step offset, so the other quadrants
  // follow by mirror and sign alone.
  function automatic int quarter_sine(input int k, input int steps, input int peak);
    real arg;
    arg = 2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / real'(4 * steps);
    return $rtoi(real'(peak) * $sin(arg) + 0.5);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FTW_W  = 32,
  parameter int POFF_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [FTW_W-1:0]  ftw_i,
  input  logic [POFF_W-1:0] poff_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int DROP = POFF_W - ADDR_W;

  logic [FTW_W-1:0]  acc_q, acc_d;
  logic [POFF_W-1:0] acc_hi;
  logic [POFF_W-1:0] ph_sum;
  logic [ADDR_W-1:0] addr_d, addr_q;

  // Next-state logic: the accumulator advances only while enabled.
  always_comb begin
    acc_d  = acc_q;
    if (en_i) acc_d = acc_q + ftw_i;
    acc_hi = POFF_W'(acc_q >> (FTW_W - POFF_W));
    ph_sum = acc_hi + poff_i;
    addr_d = ADDR_W'(ph_sum >> DROP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      addr_q <= '0;
    end else begin
      acc_q  <= acc_d;
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  // R4: a disabled oscillator keeps its phase.
  a_r4_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_q == $past(acc_q));

endmodule

// File: rtl/nco_sincos_lut.sv
module nco_sincos_lut
  import nco_upmod_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);

  localparam int QA_W = ADDR_W - 2;
  localparam int QD   = 1 << QA_W;
  localparam int PEAK = (1 << (AMP_W - 1)) - 1;

  logic [AMP_W-2:0] qrom [QD];

  for (genvar k = 0; k < QD; k++) begin : g_rom
    assign qrom[k] = (AMP_W-1)'(quarter_sine(k, QD, PEAK));
  end

  logic signed [AMP_W-1:0] wave_d [2];
  logic signed [AMP_W-1:0] wave_q [2];

  // Index 0 is sine; index 1 is the same wave a quarter turn ahead (cosine).
  for (genvar g = 0; g < 2; g++) begin : g_wave
    logic [1:0]       quad;
    logic [QA_W-1:0]  idx;
    logic [AMP_W-2:0] mag;
    always_comb begin
      quad = addr_i[ADDR_W-1 -: 2] + 2'(g);
      idx  = quad[0] ? ~addr_i[QA_W-1:0] : addr_i[QA_W-1:0];
      mag  = qrom[idx];
      wave_d[g] = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q[0] <= '0;
      wave_q[1] <= '0;
    end else begin
      wave_q[0] <= wave_d[0];
      wave_q[1] <= wave_d[1];
    end
  end

  assign sin_o = wave_q[0];
  assign cos_o = wave_q[1];

  // R6: sign of each wave follows the quadrant of the address.
  a_r6_sin_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[ADDR_W-1] |=> !sin_o[AMP_W-1]);
  a_r6_sin_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[ADDR_W-1] |=> (sin_o[AMP_W-1] || sin_o == '0));
  a_r6_cos_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1] == addr_i[ADDR_W-2]) |=> !cos_o[AMP_W-1]);

endmodule

// File: rtl/nco_cmul.sv
module nco_cmul
  import nco_upmod_pkg::*;
#(
  parameter int DW    = 12,
  parameter int AMP_W = 14
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [DW-1:0]    i_i,
  input  logic signed [DW-1:0]    q_i,
  input  logic signed [AMP_W-1:0] sin_i,
  input  logic signed [AMP_W-1:0] cos_i,
  input  mix_kind_e               kind_i,
  output logic signed [DW-1:0]    a_o,
  output logic signed [DW-1:0]    b_o
);

  localparam int PROD_W = DW + AMP_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int FRAC   = AMP_W - 1;
  localparam logic signed [SUM_W:0] HALF = (SUM_W+1)'(1 << (FRAC - 1));
  localparam logic signed [SUM_W:0] HI   = (SUM_W+1)'((1 << (DW - 1)) - 1);
  localparam logic signed [SUM_W:0] LO   = -(SUM_W+1)'(1 << (DW - 1));

  // Stage 3: four products plus the bypass copies.
  logic signed [PROD_W-1:0] p_ic_d, p_qs_d, p_is_d, p_qc_d;
  logic signed [PROD_W-1:0] p_ic_q, p_qs_q, p_is_q, p_qc_q;
  logic signed [DW-1:0]     i3_q, q3_q;
  mix_kind_e                kind3_q;

  always_comb begin
    p_ic_d = PROD_W'(i_i) * PROD_W'(cos_i);
    p_qs_d = PROD_W'(q_i) * PROD_W'(sin_i);
    p_is_d = PROD_W'(i_i) * PROD_W'(sin_i);
    p_qc_d = PROD_W'(q_i) * PROD_W'(cos_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_ic_q  <= '0;
      p_qs_q  <= '0;
      p_is_q  <= '0;
      p_qc_q  <= '0;
      i3_q    <= '0;
      q3_q    <= '0;
      kind3_q <= MIX_PASS;
    end else begin
      p_ic_q  <= p_ic_d;
      p_qs_q  <= p_qs_d;
      p_is_q  <= p_is_d;
      p_qc_q  <= p_qc_d;
      i3_q    <= i_i;
      q3_q    <= q_i;
      kind3_q <= kind_i;
    end
  end

  // Round half up, then clamp to the sample range.
  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W:0] biased;
    logic signed [SUM_W:0] shifted;
    logic signed [DW-1:0]  r;
    biased  = (SUM_W+1)'(s) + HALF;
    shifted = biased >>> FRAC;
    if (shifted > HI)      r = HI[DW-1:0];
    else if (shifted < LO) r = LO[DW-1:0];
    else                   r = DW'(shifted);
    return r;
  endfunction

  // Stage 4: combine per sideband, round, saturate.
  logic signed [SUM_W-1:0] sum_a, sum_b;
  logic signed [DW-1:0]    a_d, b_d, a_q, b_q;

  always_comb begin
    sum_a = '0;
    sum_b = '0;
    a_d   = i3_q;
    b_d   = q3_q;
    unique case (kind3_q)
      MIX_UPPER: begin
        sum_a = SUM_W'(p_ic_q) - SUM_W'(p_qs_q);
        sum_b = SUM_W'(p_is_q) + SUM_W'(p_qc_q);
        a_d   = rnd_sat(sum_a);
        b_d   = rnd_sat(sum_b);
      end
      MIX_LOWER: begin
        sum_a = SUM_W'(p_ic_q) + SUM_W'(p_qs_q);
        sum_b = SUM_W'(p_qc_q) - SUM_W'(p_is_q);
        a_d   = rnd_sat(sum_a);
        b_d   = rnd_sat(sum_b);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;

  // R9: a silent input yields silent outputs two edges on, in every mode.
  a_r9_zero_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_i == '0 && q_i == '0) |=> ##1 (a_o == '0 && b_o == '0));

endmodule

// File: rtl/nco_iq_upmod.sv
module nco_iq_upmod
  import nco_upmod_pkg::*;
#(
  parameter int DW     = 12,
  parameter int FTW_W  = 32,
  parameter int POFF_W = 16,
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 nco_en_i,
  input  logic [2:0]           mix_mode_i,
  input  logic [FTW_W-1:0]     tune_word_i,
  input  logic [POFF_W-1:0]    phase_ofs_i,
  input  logic signed [DW-1:0] samp_i_i,
  input  logic signed [DW-1:0] samp_q_i,
  output logic signed [DW-1:0] chan_a_o,
  output logic signed [DW-1:0] chan_b_o
);

  localparam int LATENCY = 4;

  // Reset: asserted at once, released after two edges.
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // Stage 1: table address; sample and mode alignment.
  logic [LUT_AW-1:0] addr1;

  nco_phase_acc #(
    .FTW_W  (FTW_W),
    .POFF_W (POFF_W),
    .ADDR_W (LUT_AW)
  ) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .en_i   (nco_en_i),
    .ftw_i  (tune_word_i),
    .poff_i (phase_ofs_i),
    .addr_o (addr1)
  );

  mix_kind_e            kind_d, kind1_q, kind2_q;
  logic signed [DW-1:0] i1_q, q1_q, i2_q, q2_q;

  always_comb kind_d = decode_mode(nco_en_i, mix_mode_i);

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      i1_q    <= '0;
      q1_q    <= '0;
      kind1_q <= MIX_PASS;
      i2_q    <= '0;
      q2_q    <= '0;
      kind2_q <= MIX_PASS;
    end else begin
      i1_q    <= samp_i_i;
      q1_q    <= samp_q_i;
      kind1_q <= kind_d;
      i2_q    <= i1_q;
      q2_q    <= q1_q;
      kind2_q <= kind1_q;
    end
  end

  // Stage 2: sine and cosine.
  logic signed [AMP_W-1:0] sin2, cos2;

  nco_sincos_lut #(
    .ADDR_W (LUT_AW),
    .AMP_W  (AMP_W)
  ) u_lut (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .addr_i (addr1),
    .sin_o  (sin2),
    .cos_o  (cos2)
  );

  // Stages 3 and 4: products, sideband combine, round and saturate.
  nco_cmul #(
    .DW    (DW),
    .AMP_W (AMP_W)
  ) u_cmul (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .i_i    (i2_q),
    .q_i    (q2_q),
    .sin_i  (sin2),
    .cos_i  (cos2),
    .kind_i (kind2_q),
    .a_o    (chan_a_o),
    .b_o    (chan_b_o)
  );

  // Counts edges since internal reset release, for the pass-through check.
  logic [2:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n)                    warm_q <= '0;
    else if (warm_q != 3'(LATENCY+1)) warm_q <= warm_q + 3'd1;
  end

  // R1: outputs are zero while the external reset is held.
  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (chan_a_o == '0 && chan_b_o == '0));

  // R3, R4: unmixed samples arrive unchanged after four edges.
  a_r3_bypass: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (warm_q == 3'(LATENCY+1) &&
     (!$past(nco_en_i, 4) ||
      ($past(mix_mode_i, 4) != MODE_UPPER && $past(mix_mode_i, 4) != MODE_LOWER)))
    |-> (chan_a_o == $past(samp_i_i, 4) && chan_b_o == $past(samp_q_i, 4)));

endmodule

// File: tb/nco_iq_upmod_tb.sv
module nco_iq_upmod_tb;

  localparam int DW = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n;
  logic                 en;
  logic [2:0]           mode;
  logic [31:0]          ftw;
  logic [15:0]          poff;
  logic signed [DW-1:0] si, sq;
  logic signed [DW-1:0] oa, ob;

  nco_iq_upmod u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .nco_en_i    (en),
    .mix_mode_i  (mode),
    .tune_word_i (ftw),
    .phase_ofs_i (poff),
    .samp_i_i    (si),
    .samp_q_i    (sq),
    .chan_a_o    (oa),
    .chan_b_o    (ob)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  int unsigned seed  = 32'h1d2c3b4a;
  longint      acc_m = 0;
  string       tag   = "R1";
  int          ea [4];
  int          eb [4];
  bit          ev [4];
  string       et [4];

  function automatic int sinv(input int p);
    real v;
    v = 8191.0 * $sin(2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int rsat(input longint s);
    longint r;
    r = (s + 4096) >>> 13;
    if (r > 2047)  r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  function automatic int rnd12();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[27:16]) - 2048;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One sample: model the expected pair, advance one clock, compare the
  // pair presented four edges earlier.
  task automatic step();
    int     p, c, s, xi, xq, xa, xb;
    longint ph;
    xi = int'(si);
    xq = int'(sq);
    ph = ((acc_m >> 16) + longint'(poff)) & 64'hFFFF;
    p  = int'(ph >> 6);
    s  = sinv(p);
    c  = sinv((p + 256) % 1024);
    if (en && mode == 3'b001) begin
      xa = rsat(longint'(xi) * c - longint'(xq) * s);
      xb = rsat(longint'(xi) * s + longint'(xq) * c);
    end else if (en && mode == 3'b010) begin
      xa = rsat(longint'(xi) * c + longint'(xq) * s);
      xb = rsat(longint'(xq) * c - longint'(xi) * s);
    end else begin
      xa = xi;
      xb = xq;
    end
    for (int k = 3; k > 0; k--) begin
      ea[k] = ea[k-1]; eb[k] = eb[k-1]; ev[k] = ev[k-1]; et[k] = et[k-1];
    end
    ea[0] = xa; eb[0] = xb; ev[0] = 1'b1; et[0] = tag;
    if (en) acc_m = (acc_m + longint'(ftw)) & 64'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    if (ev[3]) begin
      check({et[3], " chan A"}, int'(oa), ea[3]);
      check({et[3], " chan B"}, int'(ob), eb[3]);
    end
  endtask

  task automatic run_rand(input int n);
    for (int k = 0; k < n; k++) begin
      si = DW'(rnd12());
      sq = DW'(rnd12());
      step();
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      ea[k] = 0; eb[k] = 0; ev[k] = 1'b0; et[k] = "";
    end
    rst_n = 1'b0; en = 1'b0; mode = 3'b000; ftw = '0; poff = '0;
    si = '0; sq = '0;
    repeat (3) @(negedge clk);
    // R1: zero while reset is held, even with live inputs
    si = 12'sd1000; sq = -12'sd1000;
    @(negedge clk);
    check("R1 chan A", int'(oa), 0);
    check("R1 chan B", int'(ob), 0);
    si = '0; sq = '0;
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2: isolated impulses in pass-through expose any latency error
    tag = "R2"; en = 1'b1; ftw = 32'h0765_4321;
    for (int k = 0; k < 4; k++) begin
      si = '0; sq = '0;
      repeat (5) step();
      si = 12'sd777; sq = -12'sd5;
      step();
    end
    si = '0; sq = '0;
    repeat (5) step();

    // R3: pass-through codes, including the unused ones, with extremes
    tag = "R3"; ftw = 32'h0123_4567;
    for (int m = 0; m < 8; m++) begin
      if (m == 1 || m == 2) continue;
      mode = 3'(m);
      run_rand(150);
      si = 12'sh7FF; sq = 12'sh800; step();
      si = 12'sh800; sq = 12'sh7FF; step();
    end

    // R7: upper sideband at several frequencies and offsets
    tag = "R7"; mode = 3'b001;
    ftw = 32'h0400_0000; poff = 16'h0000; run_rand(400);
    ftw = 32'h1234_5679; poff = 16'h4000; run_rand(400);
    ftw = 32'hFFFF_0000; poff = 16'h9A3C; run_rand(400);

    // R8: lower sideband, same frequency set
    tag = "R8"; mode = 3'b010;
    ftw = 32'h0400_0000; poff = 16'h0000; run_rand(400);
    ftw = 32'h1234_5679; poff = 16'h4000; run_rand(400);
    ftw = 32'hFFFF_0000; poff = 16'h1F07; run_rand(400);

    // R6: every table address through a still oscillator, both sidebands
    tag = "R6"; ftw = '0;
    for (int m = 1; m <= 2; m++) begin
      mode = 3'(m);
      for (int p = 0; p < 1024; p++) begin
        poff = 16'(p << 6) | 16'h0015;
        si = 12'sd2047; sq = 12'sd0;
        step();
        si = 12'sd0; sq = -12'sd2047;
        step();
      end
    end

    // R9: full-scale inputs on both rails hit the clamp over a phase sweep
    tag = "R9"; mode = 3'b001;
    for (int p = 0; p < 1024; p += 4) begin
      poff = 16'(p << 6);
      si = 12'sd2047; sq = -12'sd2048; step();
      si = -12'sd2048; sq = -12'sd2048; step();
    end

    // R5: address carry from offset low bits into the table index
    tag = "R5"; mode = 3'b001; ftw = 32'h0003_F000; poff = 16'hFFFF;
    run_rand(600);
    poff = 16'h003F; ftw = 32'h0000_8001;
    run_rand(300);

    // R4: freeze mid-stream in a mixing mode, then resume
    tag = "R4"; mode = 3'b010; ftw = 32'h0A3D_70A4; poff = 16'h0000;
    run_rand(100);
    en = 1'b0;
    run_rand(100);
    mode = 3'b001;
    run_rand(50);
    en = 1'b1;
    run_rand(200);

    tag = "R2"; mode = 3'b000; si = '0; sq = '0;
    repeat (5) step();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule